// File: doc/BRIEF.md
# Compare-Match Toggle Timer

This block is a compare timer: a 16-bit up-counter drives five identical compare modules. Each module holds a 16-bit compare value and a small mode register. When a module is armed for toggle operation, its output pin inverts on every clock edge at which the counter steps onto the compare value. Each module also owns a sticky match flag. The flags share one control byte, and together with per-module interrupt enables they form a single interrupt request line.

Software reaches all state through a byte-wide bus with a write strobe, an address and a combinational read path. Writing the low byte of a compare value disarms the module. Writing the high byte arms it again. A 16-bit compare update is therefore glitch-free when the low byte goes first. The counter advances on a timebase tick input while the run bit is set.

Top module: `cmp_toggle_unit`

## Requirements
- R1: After reset, every output pin is 0. The control byte reads 0x00, the counter reads 0x0000 and every mode byte reads 0x00.
- R2: The control byte sits at address 0x00 and its run bit is bit 7. The counter low and high bytes read at 0x01 and 0x02. The counter rises by one on each clock where `tick` is 1 and the run bit is 1, and it wraps from 0xFFFF to 0x0000. Otherwise it holds.
- R3: Module n (n = 0..4) has its mode byte at 0x08+4n, its compare low byte at 0x09+4n and its compare high byte at 0x0A+4n. The mode bits are: bit 0 interrupt enable, bit 1 toggle, bit 2 match, bit 3 comparator enable. With bits 1, 2 and 3 all set, pin n inverts at the clock edge where the counter steps onto the module's compare value.
- R4: At that same edge, flag n (control byte bit n) becomes 1 whenever mode bits 2 and 3 are both set.
- R5: A counter that is held (no step) produces no further toggle and no further flag set, even while it equals a compare value.
- R6: When the comparator-enable bit is 0, the pin keeps its level and the flag is not set on a counter step onto the compare value.
- R7: A write to a compare low byte clears that module's comparator-enable bit. A write to a compare high byte sets it. Both changes are visible in the mode byte read.
- R8: `irq` is 1 exactly when some flag is 1 and the same module's interrupt-enable bit is 1.
- R9: Flags are never cleared by hardware. Writing the control byte loads its bits 4..0 into the flags, so writing 0 clears them.
- R10: When a control-byte write clearing a flag and a hardware set of that flag fall in the same cycle, the flag ends up 1.
- R11: With the match and comparator-enable bits set but the toggle bit clear, a step onto the compare value sets the flag and leaves the pin unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable; one counter step per high cycle while running |
| bus_addr | input | 6 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_out | output | 5 | Toggle outputs, one per module |
| irq | output | 1 | Combined flag interrupt request |

## Verification
Two events can land in the same clock: the hardware flag set from a compare hit, and a software write to the control byte that clears the flags. The bench steps the counter to one below a module's compare value. It then issues the clearing write in the very cycle that carries the final tick, so both act on the same edge. The flag must read back as 1 and the interrupt must stay asserted. A cycle-accurate reference model, compared on every clock, also covers the cases where a compare-byte write and a counter step coincide.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;

  localparam int unsigned CNT_W      = 16;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned CTRL_ADDR  = 0;
  localparam int unsigned CNTL_ADDR  = 1;
  localparam int unsigned CNTH_ADDR  = 2;
  localparam int unsigned MOD_BASE   = 8;
  localparam int unsigned MOD_STRIDE = 4;
  localparam int unsigned OFS_MODE   = 0;
  localparam int unsigned OFS_LO     = 1;
  localparam int unsigned OFS_HI     = 2;
  localparam int unsigned RUN_BIT    = 7;

  // Mode byte layout: bit3 enb, bit2 mat, bit1 tog, bit0 ie
  typedef struct packed {
    logic enb;
    logic mat;
    logic tog;
    logic ie;
  } mode_t;

  function automatic mode_t mode_from_byte(input logic [BYTE_W-1:0] b);
    mode_t m;
    m.ie  = b[0];
    m.tog = b[1];
    m.mat = b[2];
    m.enb = b[3];
    return m;
  endfunction

  function automatic logic [BYTE_W-1:0] mode_to_byte(input mode_t m);
    return {4'b0000, m.enb, m.mat, m.tog, m.ie};
  endfunction

  // A hit occurs only on the step that lands the counter on the value
  function automatic logic step_hit(input logic step,
                                    input logic [CNT_W-1:0] nxt,
                                    input logic [CNT_W-1:0] cmp);
    return step && (nxt == cmp);
  endfunction

  function automatic logic flag_arm(input mode_t m);
    return m.enb && m.mat;
  endfunction

  function automatic logic toggle_arm(input mode_t m);
    return m.enb && m.mat && m.tog;
  endfunction

  function automatic int unsigned reg_addr(input int unsigned idx,
                                           input int unsigned ofs);
    return MOD_BASE + MOD_STRIDE * idx + ofs;
  endfunction

endpackage

// File: rtl/cmpt_timebase.sv
module cmpt_timebase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  output logic             step,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);

  assign step    = tick & run;
  assign cnt_nxt = step ? cnt_q + CNT_W'(1) : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/cmpt_channel.sv
module cmpt_channel
  import cmpt_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_mode,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  input  logic          step,
  input  logic [CW-1:0] cnt_nxt,
  output logic          set_evt,
  output logic          tog_evt,
  output logic          pin,
  output logic          ie,
  output logic [DW-1:0] mode_byte,
  output logic [CW-1:0] cmp_q
);

  localparam int unsigned HALF = CW / 2;

  mode_t mode_q;
  logic  hit;

  assign hit       = step_hit(step, cnt_nxt, cmp_q);
  assign set_evt   = hit && flag_arm(mode_q);
  assign tog_evt   = hit && toggle_arm(mode_q);
  assign ie        = mode_q.ie;
  assign mode_byte = mode_to_byte(mode_q);

  // Compare bytes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else begin
      if (wr_lo) cmp_q[HALF-1:0]  <= wdata[HALF-1:0];
      if (wr_hi) cmp_q[CW-1:HALF] <= wdata[HALF-1:0];
    end
  end

  // Mode register; byte writes of the compare value move the enable bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (wr_mode) begin
      mode_q <= mode_from_byte(wdata);
    end else if (wr_lo) begin
      mode_q.enb <= 1'b0;
    end else if (wr_hi) begin
      mode_q.enb <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pin <= 1'b0;
    else if (tog_evt) pin <= ~pin;
  end

endmodule

// File: rtl/cmpt_flags.sv
module cmpt_flags #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_wr,
  input  logic [N-1:0] sw_val,
  input  logic [N-1:0] hw_set,
  output logic [N-1:0] flag_q
);

  logic [N-1:0] flag_d;

  // hardware set is applied last, so it wins over a software clear
  always_comb begin
    flag_d = sw_wr ? sw_val : flag_q;
    flag_d = flag_d | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

endmodule

// File: rtl/cmp_toggle_unit.sv
module cmp_toggle_unit
  import cmpt_pkg::*;
#(
  parameter int unsigned N_MOD  = 5,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_MOD-1:0]  pin_out,
  output logic              irq
);

  localparam int unsigned HALF = CW / 2;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_CNTL = ADDR_W'(CNTL_ADDR);
  localparam logic [ADDR_W-1:0] A_CNTH = ADDR_W'(CNTH_ADDR);

  logic             run_q;
  logic             step;
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    cnt_nxt;
  logic             ctrl_wr;
  logic [N_MOD-1:0] set_evt;
  logic [N_MOD-1:0] tog_evt;
  logic [N_MOD-1:0] flag_q;
  logic [N_MOD-1:0] ie_vec;
  logic [DATA_W-1:0] mode_rd [N_MOD];
  logic [CW-1:0]     cmp_rd  [N_MOD];

  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= 1'b0;
    else if (ctrl_wr) run_q <= bus_wdata[RUN_BIT];
  end

  cmpt_timebase #(.CNT_W(CW)) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .run     (run_q),
    .step    (step),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt)
  );

  for (genvar g = 0; g < N_MOD; g++) begin : g_mod
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(reg_addr(g, OFS_MODE));
    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(reg_addr(g, OFS_LO));
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(reg_addr(g, OFS_HI));

    cmpt_channel #(.CW(CW), .DW(DATA_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_mode   (bus_wr && (bus_addr == A_MODE)),
      .wr_lo     (bus_wr && (bus_addr == A_LO)),
      .wr_hi     (bus_wr && (bus_addr == A_HI)),
      .wdata     (bus_wdata),
      .step      (step),
      .cnt_nxt   (cnt_nxt),
      .set_evt   (set_evt[g]),
      .tog_evt   (tog_evt[g]),
      .pin       (pin_out[g]),
      .ie        (ie_vec[g]),
      .mode_byte (mode_rd[g]),
      .cmp_q     (cmp_rd[g])
    );
  end

  cmpt_flags #(.N(N_MOD)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .sw_wr  (ctrl_wr),
    .sw_val (bus_wdata[N_MOD-1:0]),
    .hw_set (set_evt),
    .flag_q (flag_q)
  );

  assign irq = |(flag_q & ie_vec);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) begin
      bus_rdata[RUN_BIT]   = run_q;
      bus_rdata[N_MOD-1:0] = flag_q;
    end
    if (bus_addr == A_CNTL) bus_rdata = DATA_W'(cnt_q[HALF-1:0]);
    if (bus_addr == A_CNTH) bus_rdata = DATA_W'(cnt_q[CW-1:HALF]);
    for (int i = 0; i < N_MOD; i++) begin
      if (bus_addr == ADDR_W'(reg_addr(i, OFS_MODE))) bus_rdata = mode_rd[i];
      if (bus_addr == ADDR_W'(reg_addr(i, OFS_LO)))   bus_rdata = DATA_W'(cmp_rd[i][HALF-1:0]);
      if (bus_addr == ADDR_W'(reg_addr(i, OFS_HI)))   bus_rdata = DATA_W'(cmp_rd[i][CW-1:HALF]);
    end
  end

endmodule

// File: rtl/cmpt_checker.sv
module cmpt_checker #(
  parameter int unsigned N  = 5,
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step,
  input logic [CW-1:0] cnt,
  input logic [N-1:0]  pins,
  input logic [N-1:0]  tog_evt,
  input logic [N-1:0]  set_evt,
  input logic [N-1:0]  flags,
  input logic          ctrl_wr,
  input logic          irq
);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt == CW'($past(cnt) + CW'(1)));                           // R2

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt));                                             // R2

  AST_PIN_FOLLOWS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    |tog_evt |=> (pins ^ $past(pins)) == $past(tog_evt));                // R3

  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tog_evt == '0 |=> $stable(pins));                                    // R6

  AST_TOG_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_evt & ~set_evt) == '0);                                         // R4

  AST_NO_EVT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |-> (set_evt == '0 && tog_evt == '0));                         // R5

  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    |set_evt |=> (flags & $past(set_evt)) == $past(set_evt));            // R10

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> (flags & $past(flags)) == $past(flags));                // R9

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flags != '0);                                                // R8

endmodule

bind cmp_toggle_unit cmpt_checker #(.N(N_MOD), .CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .step    (step),
  .cnt     (cnt_q),
  .pins    (pin_out),
  .tog_evt (tog_evt),
  .set_evt (set_evt),
  .flags   (flag_q),
  .ctrl_wr (ctrl_wr),
  .irq     (irq)
);

// File: tb/cmp_toggle_unit_tb.sv
`timescale 1ns/1ps
module cmp_toggle_unit_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [5:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [4:0] pin_out;
  logic       irq;

  always #2 clk = ~clk;

  cmp_toggle_unit u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_out(pin_out), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference state
  int m_cnt = 0;
  bit m_run = 0;
  bit m_flag[5];
  bit m_pin[5];
  bit m_ie[5], m_tog[5], m_mat[5], m_enb[5];
  int m_cmp[5];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int flag_byte();
    int v = m_run ? 128 : 0;
    for (int i = 0; i < 5; i++) if (m_flag[i]) v += (1 << i);
    return v;
  endfunction

  function automatic int model_rd(input int a);
    if (a == 0) return flag_byte();
    if (a == 1) return m_cnt & 255;
    if (a == 2) return (m_cnt >> 8) & 255;
    for (int i = 0; i < 5; i++) begin
      if (a == 8 + 4*i) return m_ie[i] + 2*m_tog[i] + 4*m_mat[i] + 8*m_enb[i];
      if (a == 9 + 4*i) return m_cmp[i] & 255;
      if (a == 10 + 4*i) return (m_cmp[i] >> 8) & 255;
    end
    return 0;
  endfunction

  function automatic int model_pins();
    int v = 0;
    for (int i = 0; i < 5; i++) if (m_pin[i]) v += (1 << i);
    return v;
  endfunction

  function automatic bit model_irq();
    for (int i = 0; i < 5; i++) if (m_flag[i] && m_ie[i]) return 1;
    return 0;
  endfunction

  task automatic model_step(input bit w, input int a, input int d, input bit t);
    bit st = t && m_run;
    int nxt = st ? ((m_cnt + 1) & 65535) : m_cnt;
    bit setv[5];
    for (int i = 0; i < 5; i++) begin
      bit hit = st && (nxt == m_cmp[i]);
      setv[i] = hit && m_enb[i] && m_mat[i];
      if (setv[i] && m_tog[i]) m_pin[i] = !m_pin[i];
    end
    m_cnt = nxt;
    if (w && a == 0) begin
      m_run = d[7];
      for (int i = 0; i < 5; i++) m_flag[i] = d[i];
    end
    for (int i = 0; i < 5; i++) begin
      if (setv[i]) m_flag[i] = 1;
      if (w && a == 8 + 4*i) begin
        m_ie[i] = d[0]; m_tog[i] = d[1]; m_mat[i] = d[2]; m_enb[i] = d[3];
      end
      if (w && a == 9 + 4*i)  begin m_cmp[i] = (m_cmp[i] & 65280) | (d & 255); m_enb[i] = 0; end
      if (w && a == 10 + 4*i) begin m_cmp[i] = (m_cmp[i] & 255) | ((d & 255) << 8); m_enb[i] = 1; end
    end
  endtask

  task automatic compare_all();
    chk(pin_out == 5'(model_pins()), "R3 pins vs model", pin_out, model_pins());
    chk(irq == model_irq(), "R8 irq vs model", irq, model_irq());
    chk(bus_rdata == 8'(model_rd(bus_addr)), "R7 rdata vs model", bus_rdata, model_rd(bus_addr));
  endtask

  task automatic cyc(input bit w, input int a, input int d, input bit t);
    bus_wr = w; bus_addr = 6'(a); bus_wdata = 8'(d); tick = t;
    model_step(w, a, d, t);
    @(posedge clk);
    @(negedge clk);
    if (!done) compare_all();
  endtask

  task automatic wr(input int a, input int d);
    cyc(1, a, d, 0);
  endtask

  task automatic run_ticks(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 1);
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    cyc(0, a, 0, 0);
    chk(bus_rdata == 8'(exp), tag, bus_rdata, exp);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000 && !done) begin
        errors++;
        $display("FAIL watchdog expired at cycle %0d expected completion", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) begin
      m_flag[i] = 0; m_pin[i] = 0; m_ie[i] = 0; m_tog[i] = 0;
      m_mat[i] = 0; m_enb[i] = 0; m_cmp[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(pin_out == 5'b0, "R1 pins after reset", pin_out, 0);
    rd_chk(0, 8'h00, "R1 control byte");
    rd_chk(1, 8'h00, "R1 counter low");
    rd_chk(2, 8'h00, "R1 counter high");
    rd_chk(8 + 4*2, 8'h00, "R1 mode byte");

    // module 0: toggle mode at 0x0005; start counter
    wr(0, 8'h80);
    wr(9, 8'h05); wr(10, 8'h00); wr(8, 8'h0F);
    // module 1: flag only at 0x0008; module 2: enable off at 0x0008
    wr(13, 8'h08); wr(14, 8'h00); wr(12, 8'h0C);
    wr(17, 8'h08); wr(18, 8'h00); wr(16, 8'h06);
    run_ticks(5);
    chk(pin_out[0] == 1'b1, "R3 pin0 toggles at 0x0005", pin_out[0], 1);
    rd_chk(0, 8'h81, "R4 flag0 set on match");
    chk(irq == 1'b1, "R8 irq with flag0 and ie0", irq, 1);

    // R5 held counter at compare value
    for (int k = 0; k < 10; k++) cyc(0, 1, 0, 0);
    chk(pin_out[0] == 1'b1, "R5 pin0 steady while held", pin_out[0], 1);
    rd_chk(1, 8'h05, "R5 counter held");

    run_ticks(3);
    chk(pin_out[1] == 1'b0, "R11 pin1 no toggle without toggle bit", pin_out[1], 0);
    chk(pin_out[2] == 1'b0, "R6 pin2 holds with enable clear", pin_out[2], 0);
    rd_chk(0, 8'h83, "R11 flag1 set, R6 flag2 clear");

    // R9 flags survive time, then clear by write
    for (int k = 0; k < 20; k++) cyc(0, 0, 0, 0);
    rd_chk(0, 8'h83, "R9 flags sticky");
    wr(0, 8'h80);
    rd_chk(0, 8'h80, "R9 flags cleared by write");
    chk(irq == 1'b0, "R8 irq drops with flags", irq, 0);

    // R7 byte writes move the enable bit
    wr(20, 8'h0F);
    rd_chk(20, 8'h0F, "R7 mode3 written");
    wr(21, 8'h40);
    rd_chk(20, 8'h07, "R7 low write disarms");
    wr(22, 8'h00);
    rd_chk(20, 8'h0F, "R7 high write arms");

    // R10 clear and hardware set in the same cycle
    wr(25, 8'h20); wr(26, 8'h00); wr(24, 8'h0F);
    run_ticks(23);
    rd_chk(1, 8'h1F, "R2 counter at 0x1F");
    cyc(1, 0, 8'h80, 1);
    rd_chk(0, 8'h90, "R10 hardware set beats clear");
    chk(pin_out[4] == 1'b1, "R3 pin4 toggles at 0x0020", pin_out[4], 1);
    chk(irq == 1'b1, "R10 irq held by flag4", irq, 1);

    // R2 run bit off: ticks ignored
    wr(0, 8'h00);
    run_ticks(5);
    rd_chk(1, 8'h20, "R2 counter stopped");

    // R2 wrap with module 0 compare at 0x0000
    wr(9, 8'h00); wr(10, 8'h00); wr(8, 8'h0F);
    wr(0, 8'h80);
    run_ticks(65535 - 32);
    rd_chk(2, 8'hFF, "R2 counter high at top");
    rd_chk(1, 8'hFF, "R2 counter low at top");
    chk(pin_out[0] == 1'b1, "R3 pin0 before wrap", pin_out[0], 1);
    run_ticks(1);
    chk(pin_out[0] == 1'b0, "R3 pin0 toggles on wrap to 0", pin_out[0], 0);
    rd_chk(1, 8'h00, "R2 wrap low");
    rd_chk(2, 8'h00, "R2 wrap high");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule